// File: doc/BRIEF.md
# Network Controller Command and Status Register Unit

This block is the host-facing command and status register set of a network controller. The host writes commands for two internal engines through a single write port: a command engine for transmit and statistics work, and a receive engine. The block holds each command in a self-clearing field and presents it to its engine on a valid/ready handshake. It also holds a general pointer register, and the block copies the pointer into the command at the moment the command is taken. Once the engine accepts the command, the field reads back as zero. The host polls for that zero before it issues the next command.

Engine events are gathered into an event byte in the upper half of a 16-bit status word. The host acknowledges an event by writing a one to its bit. A single interrupt output is the OR of the pending events, and a mask bit in the command word gates it. The lower half of the status word shows the current state codes of the two engines. The block has three registers: status at address 0, command at address 1 and pointer at address 2. Reads are registered and have a latency of one cycle.

Top module: `nic_csr_unit`

## Requirements
- R1: After reset all event bits are 0, both command fields are 0, `cu_valid` and `ru_valid` are 0, the interrupt mask (command bit 8) is 1 and `irq` is 0.
- R2: A pulse on an event input sets its status bit after the next clock edge. The bit mapping is: 15 `ev_cmd_done`, 14 `ev_frame_rx`, 13 `ev_cu_left_active`, 12 `ev_ru_left_ready`, 11 `ev_mgmt_done`, 8 `ev_fc_pause`. Status bits 9 and 1:0 always read 0.
- R3: A write to the status word clears every event bit where the written data has a 1 under mask 0xFD00. Bits written as 0 keep their value, and data bits outside the mask have no effect.
- R4: If an event input sets a bit in the same cycle that the host acknowledges that bit, the bit stays set.
- R5: Writing a command word with bit 9 set raises the software event, which is status bit 10. Command bit 9 always reads 0.
- R6: Command bit 8 is an interrupt mask that reads back as written. `irq` is 1 exactly when at least one event bit is set and the mask is 0, and it updates on the same edge as the event bits.
- R7: A command write with bits 7:4 holding a legal code (1, 2, 4, 5, 6 or 7) and no command-unit command pending makes `cu_valid` 1 with `cu_code` equal to the code. The code is held stable until the cycle `cu_ready` is 1. Command bits 7:4 read back the code while it is pending and read 0 after acceptance.
- R8: The same rules apply to the receive field. Command bits 2:0 accept legal codes 1, 2, 4, 6 and 7, drive `ru_valid` and `ru_code`, and are handshaked with `ru_ready`.
- R9: An undefined code is ignored and leaves its field at 0. The undefined codes are 3 and 8 to 15 in bits 7:4, and 3 and 5 in bits 2:0.
- R10: While a field is pending, a nonzero code written to that field is ignored, and the held code is kept until acceptance. A zero written to a field never changes it.
- R11: The pointer register (address 2) is copied into `cu_ptr` or `ru_ptr` when that engine's command is taken. Later pointer writes do not change a pending command's pointer.
- R12: Status bits 7:6 show `cu_state_i`, and status bits 5:2 show `ru_state_i`.
- R13: `rd_data` holds the register selected by `rd_addr` one cycle after the address is applied: 0 status, 1 command, 2 pointer, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register select |
| wr_data | input | PTR_W | Host write data |
| rd_addr | input | 2 | Host read register select |
| rd_data | output | PTR_W | Registered read data |
| ev_cmd_done | input | 1 | Command engine finished a command |
| ev_frame_rx | input | 1 | Frame received |
| ev_cu_left_active | input | 1 | Command engine left the active state |
| ev_ru_left_ready | input | 1 | Receive engine left the ready state |
| ev_mgmt_done | input | 1 | Management cycle finished |
| ev_fc_pause | input | 1 | Flow-control pause seen |
| cu_state_i | input | 2 | Command engine state code |
| ru_state_i | input | 4 | Receive engine state code |
| cu_valid | output | 1 | Command engine command pending |
| cu_ready | input | 1 | Command engine accepts |
| cu_code | output | 4 | Command engine command code |
| cu_ptr | output | PTR_W | Pointer captured with the command |
| ru_valid | output | 1 | Receive engine command pending |
| ru_ready | input | 1 | Receive engine accepts |
| ru_code | output | 3 | Receive engine command code |
| ru_ptr | output | PTR_W | Pointer captured with the command |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can fall in the same cycle. An engine can raise an event while the host acknowledges the same bit, and an engine can accept a command while the host writes a new code to that field. The bench drives random event pulses together with random acknowledge masks, and then tests each of these cases with a directed case. Each result is judged against a model that applies the acknowledge first and the set after it, so a set in the same cycle always survives. For the command collision, the model treats the field as still pending in that cycle, so the new code is dropped and the field reads 0 afterwards.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int EV_W = 8;            // status bits 15:8
  localparam logic [EV_W-1:0] ACK_MASK = 8'hFD;
  // event positions inside the event byte
  localparam int EV_CMD_DONE = 7;
  localparam int EV_FRAME    = 6;
  localparam int EV_CU_LEFT  = 5;
  localparam int EV_RU_LEFT  = 4;
  localparam int EV_MGMT     = 3;
  localparam int EV_SOFT     = 2;
  localparam int EV_PAUSE    = 0;
  // legal code sets, one bit per code value
  localparam logic [15:0] CU_LEGAL = 16'h00F6;
  localparam logic [7:0]  RU_LEGAL = 8'hD6;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CMD    = 2'd1,
    REG_PTR    = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/csr_event_bank.sv
module csr_event_bank
  import nic_csr_pkg::*;
#(
  parameter int W = EV_W,
  parameter logic [W-1:0] MASK = ACK_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         ack_we,
  input  logic [W-1:0] ack_i,
  input  logic         irq_mask_d,
  output logic [W-1:0] ev_o,
  output logic         irq_o
);
  logic [W-1:0] ev_q, ev_d, clr, setm;

  always_comb begin
    setm = set_i & MASK;
    clr  = ack_we ? (ack_i & MASK) : '0;
    ev_d = (ev_q & ~clr) | setm;   // set applied last: set wins
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      irq_o <= (|ev_d) & ~irq_mask_d;
    end
  end

  assign ev_o = ev_q;

  // R4: a set in the same cycle as its acknowledge survives
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ((set_i & MASK) != '0) |=> ((ev_o & $past(set_i & MASK)) == $past(set_i & MASK)));

  // R3: acknowledged bits without a concurrent set are cleared
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((ev_o & $past(ack_i & MASK & ~set_i)) == '0));

  // R2: bits outside the mask never become set
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ev_o & ~MASK) == '0));
endmodule

// File: rtl/csr_cmd_slot.sv
module csr_cmd_slot #(
  parameter int CODE_W = 4,
  parameter int PTR_W  = 32,
  parameter logic [(1<<CODE_W)-1:0] LEGAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [CODE_W-1:0] host_code,
  input  logic [PTR_W-1:0]  host_ptr,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [CODE_W-1:0] eng_code,
  output logic [PTR_W-1:0]  eng_ptr
);
  logic [CODE_W-1:0] code_q;
  logic [PTR_W-1:0]  ptr_q;
  logic pend, take, legal;

  assign pend  = (code_q != '0);
  assign legal = LEGAL[host_code];
  assign take  = host_we && !pend && (host_code != '0) && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (take) begin
      code_q <= host_code;
      ptr_q  <= host_ptr;
    end else if (pend && eng_ready) begin
      code_q <= '0;
    end
  end

  assign eng_valid = pend;
  assign eng_code  = code_q;
  assign eng_ptr   = ptr_q;

  // R7/R8: an offered command is held stable until accepted
  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_code) && $stable(eng_ptr)));

  // R7/R8: acceptance clears the field
  p_accept_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_ready) |=> !eng_valid);

  // R10: a write while pending cannot replace the held code
  p_no_overwrite_r10: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready && host_we) |=> $stable(eng_code));

  // R11: pointer only changes when a new command is taken
  p_ptr_stable_r11: assert property (@(posedge clk) disable iff (rst)
    eng_valid |=> $stable(eng_ptr));
endmodule

// File: rtl/nic_csr_unit.sv
module nic_csr_unit
  import nic_csr_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [PTR_W-1:0] rd_data,
  input  logic             ev_cmd_done,
  input  logic             ev_frame_rx,
  input  logic             ev_cu_left_active,
  input  logic             ev_ru_left_ready,
  input  logic             ev_mgmt_done,
  input  logic             ev_fc_pause,
  input  logic [1:0]       cu_state_i,
  input  logic [3:0]       ru_state_i,
  output logic             cu_valid,
  input  logic             cu_ready,
  output logic [3:0]       cu_code,
  output logic [PTR_W-1:0] cu_ptr,
  output logic             ru_valid,
  input  logic             ru_ready,
  output logic [2:0]       ru_code,
  output logic [PTR_W-1:0] ru_ptr,
  output logic             irq
);
  localparam int WORD_W = 16;

  logic wr_stat, wr_cmd, wr_ptr;
  logic mask_q, mask_d;
  logic [PTR_W-1:0] ptr_q;
  logic [EV_W-1:0]  ev_set, ev_q;
  logic [WORD_W-1:0] stat_word, cmd_word;

  assign wr_stat = wr_en && (wr_addr == REG_STATUS);
  assign wr_cmd  = wr_en && (wr_addr == REG_CMD);
  assign wr_ptr  = wr_en && (wr_addr == REG_PTR);

  assign mask_d = wr_cmd ? wr_data[8] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      ptr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_ptr) ptr_q <= wr_data;
    end
  end

  always_comb begin
    ev_set              = '0;
    ev_set[EV_CMD_DONE] = ev_cmd_done;
    ev_set[EV_FRAME]    = ev_frame_rx;
    ev_set[EV_CU_LEFT]  = ev_cu_left_active;
    ev_set[EV_RU_LEFT]  = ev_ru_left_ready;
    ev_set[EV_MGMT]     = ev_mgmt_done;
    ev_set[EV_SOFT]     = wr_cmd && wr_data[9];
    ev_set[EV_PAUSE]    = ev_fc_pause;
  end

  csr_event_bank #(.W(EV_W), .MASK(ACK_MASK)) u_events (
    .clk(clk), .rst(rst),
    .set_i(ev_set),
    .ack_we(wr_stat),
    .ack_i(wr_data[15:8]),
    .irq_mask_d(mask_d),
    .ev_o(ev_q),
    .irq_o(irq)
  );

  csr_cmd_slot #(.CODE_W(4), .PTR_W(PTR_W), .LEGAL(CU_LEGAL)) u_cu_slot (
    .clk(clk), .rst(rst),
    .host_we(wr_cmd), .host_code(wr_data[7:4]), .host_ptr(ptr_q),
    .eng_valid(cu_valid), .eng_ready(cu_ready),
    .eng_code(cu_code), .eng_ptr(cu_ptr)
  );

  csr_cmd_slot #(.CODE_W(3), .PTR_W(PTR_W), .LEGAL(RU_LEGAL)) u_ru_slot (
    .clk(clk), .rst(rst),
    .host_we(wr_cmd), .host_code(wr_data[2:0]), .host_ptr(ptr_q),
    .eng_valid(ru_valid), .eng_ready(ru_ready),
    .eng_code(ru_code), .eng_ptr(ru_ptr)
  );

  assign stat_word = {ev_q, cu_state_i, ru_state_i, 2'b00};
  assign cmd_word  = {6'b0, 1'b0, mask_q, cu_code, 1'b0, ru_code};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_STATUS: rd_data <= PTR_W'(stat_word);
        REG_CMD:    rd_data <= PTR_W'(cmd_word);
        REG_PTR:    rd_data <= ptr_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  // R6: a set mask keeps the interrupt low
  p_mask_gates_r6: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !irq);

  // R5: software interrupt request raises status bit 10
  p_soft_event_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wr_data[9]) |=> ev_q[EV_SOFT]);

  // R1: no command is offered straight out of reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!cu_valid && !ru_valid && !irq));
endmodule

// File: tb/test_nic_csr_unit.sv
module test_nic_csr_unit;
  localparam int PTR_W = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [PTR_W-1:0] wr_data = 0;
  logic [1:0] rd_addr = 0; logic [PTR_W-1:0] rd_data;
  logic e_done = 0, e_frame = 0, e_cul = 0, e_rul = 0, e_mgmt = 0, e_pause = 0;
  logic [1:0] cu_st = 2'b10; logic [3:0] ru_st = 4'b0100;
  logic cu_valid, cu_ready = 0, ru_valid, ru_ready = 0, irq;
  logic [3:0] cu_code; logic [2:0] ru_code;
  logic [PTR_W-1:0] cu_ptr, ru_ptr;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m_ev; logic m_mask;

  always #2.5 clk = ~clk;

  nic_csr_unit #(.PTR_W(PTR_W)) i_nic_csr_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_cmd_done(e_done), .ev_frame_rx(e_frame), .ev_cu_left_active(e_cul),
    .ev_ru_left_ready(e_rul), .ev_mgmt_done(e_mgmt), .ev_fc_pause(e_pause),
    .cu_state_i(cu_st), .ru_state_i(ru_st),
    .cu_valid(cu_valid), .cu_ready(cu_ready), .cu_code(cu_code), .cu_ptr(cu_ptr),
    .ru_valid(ru_valid), .ru_ready(ru_ready), .ru_code(ru_code), .ru_ptr(ru_ptr),
    .irq(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ev_pack(input logic [5:0] p);
    // p = {done, frame, cul, rul, mgmt, pause} -> bits 15,14,13,12,11,8
    return {p[5], p[4], p[3], p[2], p[1], 1'b0, 1'b0, p[0]};
  endfunction

  function automatic logic exp_irq(input logic [7:0] ev, input logic msk);
    return (|ev) & ~msk;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [PTR_W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0; wr_data = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [PTR_W-1:0] d);
    rd_addr = a; step(); d = rd_data;
  endtask

  task automatic drive_ev(input logic [5:0] p);
    {e_done, e_frame, e_cul, e_rul, e_mgmt, e_pause} = p;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PTR_W-1:0] d;
    logic [5:0] p; logic [7:0] ack;
    void'($urandom(32'h5EED));
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk(!cu_valid && !ru_valid, "R1 valids", {cu_valid, ru_valid}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    hread(2'd1, d);
    chk(d == 32'h0100, "R1 cmd word mask set", d, 32'h0100);
    hread(2'd0, d);
    chk(d == 32'h0090, "R1 R12 status word", d, 32'h0090);
    m_ev = 0; m_mask = 1;

    // R6 masked: event sets but irq stays low
    drive_ev(6'b010000); step(); drive_ev(0); m_ev |= ev_pack(6'b010000);
    chk(irq == 0, "R6 masked irq", irq, 0);
    hwrite(2'd1, 32'h0000); m_mask = 0;
    chk(irq == 1, "R6 unmasked irq", irq, 1);
    hread(2'd1, d);
    chk(d[8] == 0, "R6 mask readback", d[8], 0);

    // R2/R3/R4 random events against acknowledges
    for (int i = 0; i < 300; i++) begin
      p = 6'($urandom);
      ack = 8'($urandom);
      drive_ev(p);
      if ($urandom % 2) begin
        wr_en = 1; wr_addr = 2'd0; wr_data = {16'h0, ack, 8'($urandom)};
        m_ev = m_ev & ~(ack & 8'hFD);
      end
      m_ev = m_ev | ev_pack(p);
      step(); wr_en = 0; drive_ev(0);
      hread(2'd0, d);
      chk(d[15:8] == m_ev, "R2 R3 R4 random status", d[15:8], m_ev);
      chk(irq == exp_irq(m_ev, m_mask), "R6 random irq", irq, exp_irq(m_ev, m_mask));
    end

    // R4 directed: frame set with same-cycle ack of bit 14
    hwrite(2'd0, 32'hFFFF); m_ev = 0;
    chk(irq == 0, "R3 all cleared irq", irq, 0);
    drive_ev(6'b010000); wr_en = 1; wr_addr = 0; wr_data = 32'h4000; step();
    wr_en = 0; drive_ev(0);
    hread(2'd0, d);
    chk(d[14] == 1, "R4 set wins", d[14], 1);
    // R3 zero writes keep bit, outside-mask bits ignored
    hwrite(2'd0, 32'h02FF); hread(2'd0, d);
    chk(d[15:8] == 8'h40, "R3 zeros keep", d[15:8], 8'h40);
    hwrite(2'd0, 32'h4000); hread(2'd0, d);
    chk(d[15:8] == 8'h00, "R3 one clears", d[15:8], 0);

    // R5 software event
    hwrite(2'd1, 32'h0200); hread(2'd0, d);
    chk(d[15:8] == 8'h04, "R5 soft event bit 10", d[15:8], 8'h04);
    hread(2'd1, d);
    chk(d[9] == 0, "R5 cmd bit9 reads 0", d[9], 0);
    chk(irq == 1, "R5 R6 soft irq", irq, 1);
    hwrite(2'd0, 32'h0400);

    // R7 R11 command unit handshake
    hwrite(2'd2, 32'hA5A51234);
    hwrite(2'd1, 32'h0010);
    chk(cu_valid && cu_code == 1, "R7 cu offered", cu_code, 1);
    chk(cu_ptr == 32'hA5A51234, "R11 cu ptr", cu_ptr, 32'hA5A51234);
    hwrite(2'd2, 32'h0BADF00D);
    chk(cu_ptr == 32'hA5A51234, "R11 ptr held", cu_ptr, 32'hA5A51234);
    hwrite(2'd1, 32'h0020);
    chk(cu_code == 1, "R10 overwrite ignored", cu_code, 1);
    hread(2'd1, d);
    chk(d[7:4] == 1, "R7 pending readback", d[7:4], 1);
    // R10 collision: write in the acceptance cycle is dropped
    cu_ready = 1; wr_en = 1; wr_addr = 1; wr_data = 32'h0050; step();
    cu_ready = 0; wr_en = 0;
    chk(!cu_valid, "R7 R10 accept clears", cu_valid, 0);
    hread(2'd1, d);
    chk(d[7:4] == 0, "R7 field zero after accept", d[7:4], 0);
    hread(2'd2, d);
    chk(d == 32'h0BADF00D, "R13 pointer read", d, 32'h0BADF00D);

    // R9 undefined codes
    hwrite(2'd1, 32'h0030);
    chk(!cu_valid, "R9 cu code 3", cu_valid, 0);
    hwrite(2'd1, 32'h00F5);
    chk(!cu_valid && !ru_valid, "R9 cu 15 ru 5", {cu_valid, ru_valid}, 0);

    // R8 receive unit
    hwrite(2'd2, 32'h00C0FFEE);
    hwrite(2'd1, 32'h0004);
    chk(ru_valid && ru_code == 4 && ru_ptr == 32'h00C0FFEE, "R8 ru offered", ru_code, 4);
    hwrite(2'd1, 32'h0000);
    chk(ru_code == 4, "R10 zero write keeps", ru_code, 4);
    step(); step();
    chk(ru_valid, "R8 held", ru_valid, 1);
    ru_ready = 1; step(); ru_ready = 0;
    chk(!ru_valid, "R8 accepted", ru_valid, 0);
    hwrite(2'd1, 32'h0076);
    chk(cu_code == 7 && ru_code == 6, "R7 R8 both", {cu_code, ru_code}, {4'd7, 3'd6});
    cu_ready = 1; ru_ready = 1; step(); cu_ready = 0; ru_ready = 0;

    // R12 state codes, R13 unused address
    cu_st = 2'b01; ru_st = 4'b1001;
    hread(2'd0, d);
    chk(d[7:0] == 8'h64, "R12 state fields", d[7:0], 8'h64);
    hread(2'd3, d);
    chk(d == 0, "R13 unused address", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule